// File: doc/BRIEF.md
# Per-Area Address Setup Wait Sequencer

This block runs the address phase of an external memory bus controller. Once a bus master request is accepted, the address is put on the bus for one cycle. The block then holds off the first access cycle (T1) for a programmable number of idle setup cycles. Each of eight chip-select areas has its own setup count, stored in a 2-bit field of a 16-bit configuration word that software writes and reads as a whole.

Setup waits apply only to external SRAM and page-ROM accesses. Internal-memory accesses and all other memory types go straight from the address cycle to T1. While the address is being set up, the external wait input is masked. A configuration write that arrives during an access is parked and committed when that access completes, so an access in flight always keeps the count it started with.

Top module: `addr_setup_seq`

## Requirements
- R1: While and after reset, with no write yet, `cfg_rdata` reads 0xFFFF, `bus_phase` is IDLE and `req_ready` is 1. Phase codes are IDLE=0, ADDR_SETUP=1, SETUP_WAIT=2, T1=3.
- R2: For an external access with `req_mtype` 0 (SRAM) or 1 (page ROM) to area k, the number of consecutive SETUP_WAIT cycles equals the unsigned value of `cfg_rdata[2k+1:2k]` (0 to 3).
- R3: A request accepted at a clock edge gives exactly one ADDR_SETUP cycle, then the setup waits, then exactly one T1 cycle, then IDLE.
- R4: With `req_internal`=1 there are zero setup waits, whatever the area field holds.
- R5: With `req_mtype` 2 or 3 there are zero setup waits, whatever the area field holds.
- R6: `req_ready` is 1 only in IDLE. A `req_valid` seen outside IDLE has no effect on the phase sequence.
- R7: During ADDR_SETUP and SETUP_WAIT, `wait_mask` is 1 and `ext_wait_eff` is 0 whatever `ext_wait` does. In T1, `ext_wait_eff` follows `ext_wait` and `wait_mask` is 0.
- R8: A write (`cfg_wr_en`=1) in an IDLE or T1 cycle appears on `cfg_rdata` in the next cycle. A write in T1 overrides any parked write.
- R9: A write during ADDR_SETUP or SETUP_WAIT leaves `cfg_rdata` and the access in flight unchanged. The last such write is committed at the clock edge that ends T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Full-word configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Committed configuration word |
| req_valid | input | 1 | Access request |
| req_area | input | 3 | Chip-select area of the request |
| req_internal | input | 1 | Request targets internal memory |
| req_mtype | input | 2 | Memory type: 0 SRAM, 1 page ROM, 2/3 other |
| req_ready | output | 1 | Request accepted this cycle if valid |
| ext_wait | input | 1 | External wait input |
| ext_wait_eff | output | 1 | Wait input as passed to the data phase |
| wait_mask | output | 1 | External wait is being ignored |
| bus_phase | output | 2 | Current phase code |

## Verification
A request held in an IDLE cycle shows ADDR_SETUP in the next cycle. After that come n SETUP_WAIT cycles, one T1 cycle and IDLE, so T1 is due n+2 cycles after acceptance. A write in IDLE or T1 shows on `cfg_rdata` one cycle later. A parked write shows in the first IDLE cycle after T1. The bench drives inputs and samples outputs on the falling edge and steps one cycle at a time through each access. Every phase, mask and read-back value is compared in the exact cycle it is due, against a bench model of the register and the field decode.

// File: rtl/asw_pkg.sv
package asw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_WAIT = 2'd2,
      PH_T1   = 2'd3
   } phase_e;

   localparam logic [1:0] MT_SRAM = 2'd0;
   localparam logic [1:0] MT_PROM = 2'd1;
endpackage

// File: rtl/asw_cfg_reg.sv
module asw_cfg_reg #(
   parameter int CFG_W = 16,
   parameter logic [CFG_W-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wdata,
   input  logic             commit_ok,
   output logic [CFG_W-1:0] cfg_q
);
   logic [CFG_W-1:0] park_q;
   logic             park_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= RST_VAL;
         park_q <= '0;
         park_v <= 1'b0;
      end else if (commit_ok) begin
         if (wr_en)       cfg_q <= wdata;
         else if (park_v) cfg_q <= park_q;
         park_v <= 1'b0;
      end else if (wr_en) begin
         park_q <= wdata;
         park_v <= 1'b1;
      end
   end
endmodule

// File: rtl/asw_field_sel.sv
module asw_field_sel
   import asw_pkg::*;
#(
   parameter int NUM_AREAS  = 8,
   parameter int CNT_W      = 2,
   parameter bit PROM_SETUP = 1'b1,
   localparam int CFG_W     = NUM_AREAS * CNT_W,
   localparam int SEL_W     = $clog2(NUM_AREAS)
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic [SEL_W-1:0] area,
   input  logic             internal,
   input  logic [1:0]       mtype,
   output logic [CNT_W-1:0] waits
);
   logic [CNT_W-1:0] fld [NUM_AREAS];
   logic             type_ok;

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_fld
      assign fld[g] = cfg[g*CNT_W +: CNT_W];
   end

   if (PROM_SETUP) begin : g_prom
      assign type_ok = (mtype == MT_SRAM) || (mtype == MT_PROM);
   end else begin : g_sram_only
      assign type_ok = (mtype == MT_SRAM);
   end

   always_comb begin
      waits = '0;
      if (!internal && type_ok) waits = fld[area];
   end
endmodule

// File: rtl/asw_phase_fsm.sv
module asw_phase_fsm
   import asw_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] load_waits,
   input  logic             ext_wait,
   output phase_e           phase,
   output logic             req_ready,
   output logic             wait_mask,
   output logic             ext_wait_eff,
   output logic             commit_ok
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (req_valid) begin
               phase <= PH_ADDR;
               cnt_q <= load_waits;
            end
            PH_ADDR: phase <= (cnt_q == '0) ? PH_T1 : PH_WAIT;
            PH_WAIT: begin
               if (cnt_q == ONE) phase <= PH_T1;
               cnt_q <= cnt_q - ONE;
            end
            PH_T1:   phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign req_ready    = (phase == PH_IDLE);
   assign wait_mask    = (phase == PH_ADDR) || (phase == PH_WAIT);
   assign ext_wait_eff = ext_wait && (phase == PH_T1);
   assign commit_ok    = (phase == PH_IDLE) || (phase == PH_T1);
endmodule

// File: rtl/addr_setup_seq.sv
module addr_setup_seq
   import asw_pkg::*;
#(
   parameter int NUM_AREAS  = 8,
   parameter int CNT_W      = 2,
   parameter bit PROM_SETUP = 1'b1,
   localparam int CFG_W     = NUM_AREAS * CNT_W,
   localparam int SEL_W     = $clog2(NUM_AREAS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             req_valid,
   input  logic [SEL_W-1:0] req_area,
   input  logic             req_internal,
   input  logic [1:0]       req_mtype,
   output logic             req_ready,
   input  logic             ext_wait,
   output logic             ext_wait_eff,
   output logic             wait_mask,
   output logic [1:0]       bus_phase
);
   if (NUM_AREAS < 2 || (1 << SEL_W) != NUM_AREAS) begin : g_bad_areas
      $error("NUM_AREAS must be a power of two of at least 2");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must lie in 1..8");
   end

   logic [CNT_W-1:0] sel_waits;
   logic             commit_ok;
   phase_e           phase;

   asw_cfg_reg #(.CFG_W(CFG_W), .RST_VAL({CFG_W{1'b1}})) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr_en),
      .wdata     (cfg_wdata),
      .commit_ok (commit_ok),
      .cfg_q     (cfg_rdata)
   );

   asw_field_sel #(.NUM_AREAS(NUM_AREAS), .CNT_W(CNT_W), .PROM_SETUP(PROM_SETUP)) u_sel (
      .cfg      (cfg_rdata),
      .area     (req_area),
      .internal (req_internal),
      .mtype    (req_mtype),
      .waits    (sel_waits)
   );

   asw_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .load_waits   (sel_waits),
      .ext_wait     (ext_wait),
      .phase        (phase),
      .req_ready    (req_ready),
      .wait_mask    (wait_mask),
      .ext_wait_eff (ext_wait_eff),
      .commit_ok    (commit_ok)
   );

   assign bus_phase = phase;
endmodule

// File: rtl/addr_setup_seq_chk.sv
module addr_setup_seq_chk #(
   parameter int CFG_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic             req_valid,
   input logic             req_internal,
   input logic             req_ready,
   input logic             ext_wait,
   input logic             ext_wait_eff,
   input logic [1:0]       bus_phase
);
   assert_addr_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_phase == 2'd1 |=> (bus_phase == 2'd2 || bus_phase == 2'd3));

   assert_t1_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_phase == 2'd3 |=> bus_phase == 2'd0);

   assert_internal_nowait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_phase == 2'd0 && req_valid && req_internal) |=> bus_phase == 2'd1 ##1 bus_phase == 2'd3);

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> bus_phase == 2'd0);

   assert_wait_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_phase == 2'd1 || bus_phase == 2'd2) && ext_wait |-> !ext_wait_eff);

   assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_phase == 2'd1 || bus_phase == 2'd2) |=> $stable(cfg_rdata));
endmodule

bind addr_setup_seq addr_setup_seq_chk #(.CFG_W(CFG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_rdata    (cfg_rdata),
   .req_valid    (req_valid),
   .req_internal (req_internal),
   .req_ready    (req_ready),
   .ext_wait     (ext_wait),
   .ext_wait_eff (ext_wait_eff),
   .bus_phase    (bus_phase)
);

// File: tb/addr_setup_seq_test.sv
`timescale 1ns/1ps
module addr_setup_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [2:0]  req_area = '0;
   logic        req_internal = 1'b0;
   logic [1:0]  req_mtype = '0;
   logic        req_ready;
   logic        ext_wait = 1'b0;
   logic        ext_wait_eff;
   logic        wait_mask;
   logic [1:0]  bus_phase;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] model = 16'hFFFF;
   logic [15:0] park = '0;
   bit          park_v = 1'b0;

   always #2 clk = ~clk;

   addr_setup_seq uut (.*);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_waits(input logic [15:0] c, input int area, input bit intl, input bit [1:0] mt);
      if (intl || mt > 2'd1) return 0;
      return int'(c[2*area +: 2]);
   endfunction

   task automatic idle_write(input logic [15:0] v);
      cfg_wr_en = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      model = v;
      chk(cfg_rdata == v, "R8 idle write", 32'(cfg_rdata), 32'(v));
   endtask

   task automatic run_access(input int area, input bit intl, input bit [1:0] mt,
                             input bit mid_wr, input logic [15:0] mid_val,
                             input bit t1_wr, input logic [15:0] t1_val, input bit noise);
      int n;
      string tg;
      n = exp_waits(model, area, intl, mt);
      tg = intl ? "R4" : (mt > 2'd1) ? "R5" : "R2";
      chk(bus_phase == 2'd0, "R3 start idle", 32'(bus_phase), 0);
      req_valid = 1'b1; req_area = 3'(area); req_internal = intl; req_mtype = mt;
      ext_wait = 1'($urandom);
      @(negedge clk);
      req_valid = noise; req_area = 3'($urandom); req_internal = 1'($urandom); req_mtype = 2'($urandom);
      chk(bus_phase == 2'd1, "R3 addr setup", 32'(bus_phase), 1);
      chk(req_ready == 1'b0, "R6 busy ready", 32'(req_ready), 0);
      chk(wait_mask == 1'b1 && ext_wait_eff == 1'b0, "R7 addr mask", {wait_mask, ext_wait_eff}, 2);
      if (mid_wr) begin
         cfg_wr_en = 1'b1; cfg_wdata = mid_val; park = mid_val; park_v = 1'b1;
      end
      ext_wait = 1'($urandom);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_wr_en = 1'b0;
         chk(bus_phase == 2'd2, {tg, " setup wait"}, 32'(bus_phase), 2);
         chk(wait_mask == 1'b1 && ext_wait_eff == 1'b0, "R7 wait mask", {wait_mask, ext_wait_eff}, 2);
         chk(cfg_rdata == model, "R9 held", 32'(cfg_rdata), 32'(model));
         ext_wait = 1'($urandom);
      end
      @(negedge clk);
      cfg_wr_en = 1'b0;
      chk(bus_phase == 2'd3, {tg, " T1 due"}, 32'(bus_phase), 3);
      chk(wait_mask == 1'b0 && ext_wait_eff == ext_wait, "R7 T1 pass", {wait_mask, ext_wait_eff}, {1'b0, ext_wait});
      chk(cfg_rdata == model, "R9 held in T1", 32'(cfg_rdata), 32'(model));
      if (t1_wr) begin
         cfg_wr_en = 1'b1; cfg_wdata = t1_val;
      end
      @(negedge clk);
      cfg_wr_en = 1'b0; req_valid = 1'b0;
      if (t1_wr) model = t1_val;
      else if (park_v) model = park;
      park_v = 1'b0;
      chk(bus_phase == 2'd0 && req_ready == 1'b1, "R6 back idle", {bus_phase, req_ready}, 1);
      chk(cfg_rdata == model, t1_wr ? "R8 T1 write" : "R9 commit", 32'(cfg_rdata), 32'(model));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R3 watchdog act=%0d exp=0", n_cmp);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk(cfg_rdata == 16'hFFFF && bus_phase == 2'd0 && req_ready, "R1 in reset", {cfg_rdata, bus_phase, req_ready}, {16'hFFFF, 3'b001});
      rst_n = 1'b1;
      @(negedge clk);
      chk(cfg_rdata == 16'hFFFF, "R1 reset value", 32'(cfg_rdata), 32'hFFFF);
      chk(bus_phase == 2'd0 && req_ready, "R1 idle ready", {bus_phase, req_ready}, 1);
      // R2: default three waits in every area
      for (int a = 0; a < 8; a++) run_access(a, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0);
      // R2: area k in bits [2k+1:2k], counts 0..3
      idle_write(16'he4e4);
      for (int a = 0; a < 8; a++) run_access(a, 1'b0, 2'(a & 1), 1'b0, '0, 1'b0, '0, 1'b1);
      // R4 / R5 with maximum field
      idle_write(16'hFFFF);
      run_access(5, 1'b1, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0);
      run_access(2, 1'b0, 2'd2, 1'b0, '0, 1'b0, '0, 1'b0);
      run_access(7, 1'b0, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1);
      // R9: mid-access write keeps in-flight count, commits after T1
      run_access(1, 1'b0, 2'd0, 1'b1, 16'h0000, 1'b0, '0, 1'b0);
      run_access(1, 1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0);
      // R8: write in T1 overrides parked one
      run_access(0, 1'b0, 2'd1, 1'b1, 16'h5555, 1'b1, 16'haaaa, 1'b0);
      run_access(0, 1'b0, 2'd1, 1'b0, '0, 1'b0, '0, 1'b0);
      // random mix
      for (int k = 0; k < 400; k++) begin
         if ($urandom % 4 == 0) idle_write(16'($urandom));
         run_access(int'($urandom % 8), ($urandom % 4) == 0, 2'($urandom),
                    1'($urandom), 16'($urandom), ($urandom % 5) == 0, 16'($urandom), 1'($urandom));
         if ($urandom % 3 == 0) @(negedge clk);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule